// File: doc/BRIEF.md
# Interrupt and Sequence Status Unit for a SCSI Controller

This block owns the status, interrupt-cause and sequence-step registers of a SCSI host controller together with its single interrupt line. The command engine and data mover around it post events through one strobe with a kind code. These events are flush, bus reset, missing target, bus service, message done and transfer done. Completion of a command arrives on a separate strobe that carries the SCSI status byte. The host reads the registers through a small read port. Reading the interrupt-cause register acknowledges the interrupt.

A completion that turns up while an earlier interrupt is still unacknowledged is parked in a one-deep holder. It is posted on the first cycle after the acknowledge, so the host sees the line drop for one cycle and then rise again with the completion cause. A soft-reset strobe returns every register to zero. It also drops the interrupt and data-request lines and discards any parked completion.

Top module: `scsi_irq_status`

## Requirements
- R1: After rst_n is released, irq and drq are low and every readable register reads 0x00.
- R2: irq is the interrupt bit (bit 7) of the status register. A second raising event while it is already set leaves it high, with no extra rising edge.
- R3: A read of address 1 (interrupt cause) returns, one cycle later, the value held before the read. On the same edge it clears the cause register, the interrupt bit and the count-zero bit (bit 4), and sets the sequence step (address 2) to 0x04.
- R4: A completion that arrives while the interrupt bit is set changes no register. It is held, and a later completion overwrites the held status byte.
- R5: A held completion is posted on the edge after the one that cleared the interrupt bit, so irq is low for exactly one cycle in between.
- R6: Posting a completion sets the status register to 0x93 (interrupt, count zero, status phase 3). It also sets the cause to 0x10, clears the sequence step, FIFO flags (address 3) and transfer count (addresses 4 low byte, 5 high byte), and stores the status byte at address 6.
- R7: Event kind 1 (bus reset) sets the cause to 0x80. It raises the interrupt only while cfg_rst_quiet is low.
- R8: Event kind 2 (missing target) sets the status to zero, the cause to 0x20 and the sequence step to 0, and then raises the interrupt.
- R9: Event kind 0 (flush) sets the cause to 0x08 and clears the sequence step and the FIFO flags. It does not raise the interrupt.
- R10: Event kind 3 (bus service) sets the status to count zero plus the phase given on ev_phase, the cause to 0x18 and the sequence step to 0x04, and raises the interrupt.
- R11: Event kind 4 (message done) sets the cause to 0x20 and clears the sequence step and flags, then raises the interrupt. Kind 5 (transfer done) sets count zero, sets the cause to 0x10, clears the sequence step, flags and count, and raises the interrupt. Kinds 6 and 7 have no effect.
- R12: When an event and an interrupt-cause read fall in the same cycle, the read returns the old cause and the event's effects are applied after the acknowledge.
- R13: soft_rst clears all registers, drops irq and drq, and discards a held completion. drq is set by drq_raise and cleared by drq_drop, and drq_drop wins.
- R14: tc_ld loads the 16-bit transfer count and clears the count-zero bit. ff_ld loads the FIFO flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Soft reset strobe |
| cfg_rst_quiet | input | 1 | Suppress interrupt on bus reset |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 3 | Event kind code |
| ev_phase | input | 3 | Bus phase for bus-service event |
| cmp_valid | input | 1 | Command completion strobe |
| cmp_status | input | 8 | SCSI status byte of completion |
| tc_ld | input | 1 | Transfer count load strobe |
| tc_val | input | 16 | Transfer count value |
| ff_ld | input | 1 | FIFO flags load strobe |
| ff_val | input | 8 | FIFO flags value |
| drq_raise | input | 1 | Set data request |
| drq_drop | input | 1 | Clear data request |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| irq | output | 1 | Interrupt line |
| drq | output | 1 | Data request line |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |

## Verification
Two functions can land on the same edge: the host acknowledge, which is a read of the cause register, and an event posting. The bench drives both on one cycle, once with a raising bus-service event and once with a non-raising flush. It judges the result by the returned old cause, the level of irq after the edge and the cause read afterwards. A behavioural model that applies the acknowledge first and the event second is compared with irq, drq and rd_data on every clock.

// File: rtl/sis_pkg.sv
// Package: shared widths, register layout, codes and the register bundle
// for the interrupt/status unit. Assumes byte-wide host registers.
package sis_pkg;
    localparam int DW        = 8;
    localparam int CNT_W     = 16;
    localparam int AW        = 3;
    localparam int CNT_BYTES = CNT_W / DW;

    // event kind codes
    localparam logic [2:0] EV_FLUSH     = 3'd0;
    localparam logic [2:0] EV_BUS_RESET = 3'd1;
    localparam logic [2:0] EV_NO_TARGET = 3'd2;
    localparam logic [2:0] EV_BUS_SVC   = 3'd3;
    localparam logic [2:0] EV_MSG_DONE  = 3'd4;
    localparam logic [2:0] EV_XFER_DONE = 3'd5;

    // status register bit positions
    localparam int ST_INT = 7;
    localparam int ST_TC  = 4;
    localparam logic [2:0] PH_STATUS = 3'd3;

    // interrupt cause codes
    localparam logic [DW-1:0] CAUSE_FUNC_DONE = 8'h08;
    localparam logic [DW-1:0] CAUSE_BUS_SVC   = 8'h10;
    localparam logic [DW-1:0] CAUSE_DISC      = 8'h20;
    localparam logic [DW-1:0] CAUSE_BUS_RST   = 8'h80;
    localparam logic [DW-1:0] SEQ_CMD_DONE    = 8'h04;

    // read addresses
    localparam logic [AW-1:0] A_STAT  = 3'd0;
    localparam logic [AW-1:0] A_CAUSE = 3'd1;
    localparam logic [AW-1:0] A_SEQ   = 3'd2;
    localparam logic [AW-1:0] A_FLAGS = 3'd3;
    localparam logic [AW-1:0] A_CNT0  = 3'd4;
    localparam logic [AW-1:0] A_CSTAT = 3'd6;

    typedef struct packed {
        logic [DW-1:0]    stat;
        logic [DW-1:0]    cause;
        logic [DW-1:0]    seq;
        logic [DW-1:0]    flags;
        logic [CNT_W-1:0] tcnt;
        logic [DW-1:0]    cstat;
    } regs_t;
endpackage

// File: rtl/sis_defer.sv
// One-deep holder for a completion that arrives while the interrupt bit
// is set. Assumes int_q is the registered interrupt bit and ack is the
// cause-register read of this cycle. Emits at most one report per cycle.
module sis_defer
    import sis_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          int_q,
    input  logic          ack,
    input  logic          cmp_valid,
    input  logic [DW-1:0] cmp_status,
    output logic          report,
    output logic [DW-1:0] report_status
);
    logic          pend_q;
    logic [DW-1:0] pend_st_q;
    logic          release_now;
    logic          int_mid;
    logic          hold;
    logic          direct;

    // decide release, direct post or hold for this cycle
    always_comb begin
        release_now   = pend_q && !int_q;
        int_mid       = release_now || (int_q && !ack);
        hold          = cmp_valid && int_mid;
        direct        = cmp_valid && !int_mid;
        report        = release_now || direct;
        report_status = release_now ? pend_st_q : cmp_status;
    end

    // held completion storage
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            pend_q    <= 1'b0;
            pend_st_q <= '0;
        end else if (hold) begin
            pend_q    <= 1'b1;
            pend_st_q <= cmp_status;
        end else if (release_now) begin
            pend_q    <= 1'b0;
        end
    end

    // R4: completion during a pending interrupt is parked
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && int_q && !ack && !soft_rst) |=> (pend_q && pend_st_q == $past(cmp_status)));
    // R5: a parked completion leaves once the interrupt bit is clear
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !int_q && !cmp_valid && !soft_rst) |=> !pend_q);
    // R13: soft reset discards the held completion
    a_r13_drop_pend: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !pend_q);
endmodule

// File: rtl/sis_regs.sv
// Status, cause, sequence, flags, count and completion-status registers
// plus the data-request flop. Updates are applied in a fixed order each
// cycle: loads, acknowledge, completion post, then event, so an event
// always overrides an acknowledge in the same cycle.
module sis_regs
    import sis_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cfg_rst_quiet,
    input  logic             ack,
    input  logic             report,
    input  logic [DW-1:0]    report_status,
    input  logic             ev_valid,
    input  logic [2:0]       ev_kind,
    input  logic [2:0]       ev_phase,
    input  logic             tc_ld,
    input  logic [CNT_W-1:0] tc_val,
    input  logic             ff_ld,
    input  logic [DW-1:0]    ff_val,
    input  logic             drq_raise,
    input  logic             drq_drop,
    output regs_t            q,
    output logic             drq_q
);
    regs_t n;
    logic  n_drq;

    // ordered next-state chain
    always_comb begin
        n     = q;
        n_drq = drq_q;
        if (tc_ld) begin
            n.tcnt        = tc_val;
            n.stat[ST_TC] = 1'b0;
        end
        if (ff_ld) begin
            n.flags = ff_val;
        end
        if (ack) begin
            n.cause        = '0;
            n.seq          = SEQ_CMD_DONE;
            n.stat[ST_TC]  = 1'b0;
            n.stat[ST_INT] = 1'b0;
        end
        if (report) begin
            n.cstat        = report_status;
            n.stat         = '0;
            n.stat[2:0]    = PH_STATUS;
            n.stat[ST_TC]  = 1'b1;
            n.stat[ST_INT] = 1'b1;
            n.cause        = CAUSE_BUS_SVC;
            n.seq          = '0;
            n.flags        = '0;
            n.tcnt         = '0;
        end
        if (ev_valid) begin
            case (ev_kind)
                EV_FLUSH: begin
                    n.cause = CAUSE_FUNC_DONE;
                    n.seq   = '0;
                    n.flags = '0;
                end
                EV_BUS_RESET: begin
                    n.cause = CAUSE_BUS_RST;
                    if (!cfg_rst_quiet) n.stat[ST_INT] = 1'b1;
                end
                EV_NO_TARGET: begin
                    n.stat         = '0;
                    n.stat[ST_INT] = 1'b1;
                    n.cause        = CAUSE_DISC;
                    n.seq          = '0;
                end
                EV_BUS_SVC: begin
                    n.stat         = '0;
                    n.stat[2:0]    = ev_phase;
                    n.stat[ST_TC]  = 1'b1;
                    n.stat[ST_INT] = 1'b1;
                    n.cause        = CAUSE_BUS_SVC | CAUSE_FUNC_DONE;
                    n.seq          = SEQ_CMD_DONE;
                end
                EV_MSG_DONE: begin
                    n.cause        = CAUSE_DISC;
                    n.seq          = '0;
                    n.flags        = '0;
                    n.stat[ST_INT] = 1'b1;
                end
                EV_XFER_DONE: begin
                    n.stat[ST_TC]  = 1'b1;
                    n.stat[ST_INT] = 1'b1;
                    n.cause        = CAUSE_BUS_SVC;
                    n.seq          = '0;
                    n.flags        = '0;
                    n.tcnt         = '0;
                end
                default: ;
            endcase
        end
        if (drq_drop)       n_drq = 1'b0;
        else if (drq_raise) n_drq = 1'b1;
    end

    // register update with hard and soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            q     <= '0;
            drq_q <= 1'b0;
        end else begin
            q     <= n;
            drq_q <= n_drq;
        end
    end

    // R2: the interrupt bit only rises on a posting
    a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stat[ST_INT]) |-> $past(report || ev_valid));
    // R3: a lone acknowledge clears cause and drops the line
    a_r3_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !report && !ev_valid && !soft_rst) |=>
        (!q.stat[ST_INT] && !q.stat[ST_TC] && q.cause == 8'h00 && q.seq == 8'h04));
    // R6: posted completion register image
    a_r6_post: assert property (@(posedge clk) disable iff (!rst_n)
        (report && !ev_valid && !soft_rst) |=>
        (q.stat == 8'h93 && q.cause == 8'h10 && q.tcnt == '0 && q.flags == 8'h00));
    // R7: quiet bus reset leaves the line low
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_BUS_RESET && cfg_rst_quiet && !q.stat[ST_INT]
         && !report && !soft_rst) |=> !q.stat[ST_INT]);
    // R9: flush never raises
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_FLUSH && !q.stat[ST_INT] && !report && !soft_rst)
        |=> (!q.stat[ST_INT] && q.seq == 8'h00 && q.flags == 8'h00));
    // R12: an event beside an acknowledge wins
    a_r12_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ev_valid && ev_kind == EV_BUS_SVC && !soft_rst) |=>
        (q.stat[ST_INT] && q.cause == 8'h18));
    // R13: soft reset clears lines and status
    a_r13_soft: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!q.stat[ST_INT] && !drq_q && q.stat == 8'h00));
endmodule

// File: rtl/sis_rdport.sv
// Host read port: registered read data and acknowledge decode. Assumes
// the register bundle is the pre-update state, so reads see old values.
module sis_rdport
    import sis_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  regs_t         q,
    output logic          ack,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] cnt_byte [CNT_BYTES];
    logic [DW-1:0] mux;

    // slice the transfer count into readable bytes
    for (genvar i = 0; i < CNT_BYTES; i++) begin : g_cnt
        assign cnt_byte[i] = q.tcnt[i*DW +: DW];
    end

    // address decode
    always_comb begin
        ack = rd_en && (rd_addr == A_CAUSE);
        mux = '0;
        case (rd_addr)
            A_STAT:  mux = q.stat;
            A_CAUSE: mux = q.cause;
            A_SEQ:   mux = q.seq;
            A_FLAGS: mux = q.flags;
            A_CSTAT: mux = q.cstat;
            default: ;
        endcase
        for (int i = 0; i < CNT_BYTES; i++) begin
            if (rd_addr == AW'(A_CNT0 + i)) mux = cnt_byte[i];
        end
    end

    // read data register
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mux;
    end

    // R3: a cause read returns the value before the acknowledge
    a_r3_old_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_CAUSE) |=> (rd_data == $past(q.cause)));
endmodule

// File: rtl/scsi_irq_status.sv
// Top: interrupt, status and sequence unit. Wires the read port, the
// completion holder and the register block. irq is the status INT bit.
module scsi_irq_status
    import sis_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cfg_rst_quiet,
    input  logic             ev_valid,
    input  logic [2:0]       ev_kind,
    input  logic [2:0]       ev_phase,
    input  logic             cmp_valid,
    input  logic [DW-1:0]    cmp_status,
    input  logic             tc_ld,
    input  logic [CNT_W-1:0] tc_val,
    input  logic             ff_ld,
    input  logic [DW-1:0]    ff_val,
    input  logic             drq_raise,
    input  logic             drq_drop,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic             irq,
    output logic             drq,
    output logic [DW-1:0]    rd_data
);
    regs_t         q;
    logic          ack;
    logic          report;
    logic [DW-1:0] report_status;

    sis_rdport u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .q       (q),
        .ack     (ack),
        .rd_data (rd_data)
    );

    sis_defer u_defer (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .int_q         (q.stat[ST_INT]),
        .ack           (ack),
        .cmp_valid     (cmp_valid),
        .cmp_status    (cmp_status),
        .report        (report),
        .report_status (report_status)
    );

    sis_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .cfg_rst_quiet (cfg_rst_quiet),
        .ack           (ack),
        .report        (report),
        .report_status (report_status),
        .ev_valid      (ev_valid),
        .ev_kind       (ev_kind),
        .ev_phase      (ev_phase),
        .tc_ld         (tc_ld),
        .tc_val        (tc_val),
        .ff_ld         (ff_ld),
        .ff_val        (ff_val),
        .drq_raise     (drq_raise),
        .drq_drop      (drq_drop),
        .q             (q),
        .drq_q         (drq)
    );

    assign irq = q.stat[ST_INT];
endmodule

// File: tb/scsi_irq_status_test.sv
module scsi_irq_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, cfg_rst_quiet = 0, ev_valid = 0, cmp_valid = 0;
    logic [2:0] ev_kind = 0, ev_phase = 0, rd_addr = 0;
    logic [7:0] cmp_status = 0, ff_val = 0;
    logic [15:0] tc_val = 0;
    logic tc_ld = 0, ff_ld = 0, drq_raise = 0, drq_drop = 0, rd_en = 0;
    logic irq, drq;
    logic [7:0] rd_data;

    int checks = 0, fails = 0, rises = 0;
    string cur_req = "R1";
    logic irq_prev = 0;

    always #5 clk = ~clk;

    scsi_irq_status uut (.*);

    // behavioural reference model
    logic [7:0] ms = 0, mc = 0, mq = 0, mf = 0, mcs = 0, mrd = 0;
    logic [15:0] mt = 0;
    logic md = 0;
    logic [7:0] pq[$];

    task automatic post(input logic [7:0] st);
        mcs = st; ms = 8'h93; mc = 8'h10; mq = 0; mf = 0; mt = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mc = 0; mq = 0; mf = 0; mcs = 0; mrd = 0; mt = 0; md = 0;
            pq.delete();
        end else begin
            if (rd_en) begin
                case (rd_addr)
                    0: mrd = ms;  1: mrd = mc;  2: mrd = mq;  3: mrd = mf;
                    4: mrd = mt[7:0];  5: mrd = mt[15:8];  6: mrd = mcs;
                    default: mrd = 0;
                endcase
            end
            if (soft_rst) begin
                ms = 0; mc = 0; mq = 0; mf = 0; mcs = 0; mt = 0; md = 0;
                pq.delete();
            end else begin
                automatic bit rel = (pq.size() > 0) && !ms[7];
                if (tc_ld) begin mt = tc_val; ms[4] = 0; end
                if (ff_ld) mf = ff_val;
                if (rd_en && rd_addr == 1) begin mc = 0; mq = 4; ms[4] = 0; ms[7] = 0; end
                if (rel) post(pq.pop_front());
                if (cmp_valid) begin
                    if (ms[7]) begin pq.delete(); pq.push_back(cmp_status); end
                    else post(cmp_status);
                end
                if (ev_valid) begin
                    case (ev_kind)
                        0: begin mc = 8'h08; mq = 0; mf = 0; end
                        1: begin mc = 8'h80; if (!cfg_rst_quiet) ms[7] = 1; end
                        2: begin ms = 8'h80; mc = 8'h20; mq = 0; end
                        3: begin ms = 8'h90 | {5'd0, ev_phase}; mc = 8'h18; mq = 4; end
                        4: begin mc = 8'h20; mq = 0; mf = 0; ms[7] = 1; end
                        5: begin ms[4] = 1; ms[7] = 1; mc = 8'h10; mq = 0; mf = 0; mt = 0; end
                        default: ;
                    endcase
                end
                if (drq_drop) md = 0; else if (drq_raise) md = 1;
            end
        end
    end

    // per-clock comparison and rising-edge count
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (irq !== ms[7] || drq !== md || rd_data !== mrd) begin
                fails++;
                $display("FAIL %s model compare: irq/drq/rd %0b/%0b/%02h expected %0b/%0b/%02h",
                         cur_req, irq, drq, rd_data, ms[7], md, mrd);
            end
            if (irq && !irq_prev) rises++;
            irq_prev = irq;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic ev(input logic [2:0] k, input logic [2:0] ph);
        ev_valid = 1; ev_kind = k; ev_phase = ph; tick(); ev_valid = 0;
    endtask
    task automatic cmp(input logic [7:0] s);
        cmp_valid = 1; cmp_status = s; tick(); cmp_valid = 0;
    endtask
    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_en = 1; rd_addr = a; tick(); rd_en = 0; v = rd_data;
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int r0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        // R1
        cur_req = "R1";
        chk("R1 irq", irq, 0); chk("R1 drq", drq, 0);
        rd(0, v); chk("R1 stat", v, 8'h00);
        rd(1, v); chk("R1 cause", v, 8'h00);
        // R14
        cur_req = "R14";
        tc_ld = 1; tc_val = 16'h1234; ff_ld = 1; ff_val = 8'h05; tick(); tc_ld = 0; ff_ld = 0;
        rd(4, v); chk("R14 count lo", v, 8'h34);
        rd(5, v); chk("R14 count hi", v, 8'h12);
        rd(3, v); chk("R14 flags", v, 8'h05);
        // R10 and R3
        cur_req = "R10";
        ev(3, 2); chk("R10 irq", irq, 1);
        rd(0, v); chk("R10 stat", v, 8'h92);
        rd(2, v); chk("R10 seq", v, 8'h04);
        cur_req = "R3";
        rd(1, v); chk("R3 old cause", v, 8'h18); chk("R3 irq low", irq, 0);
        rd(0, v); chk("R3 stat", v, 8'h02);
        rd(1, v); chk("R3 cause cleared", v, 8'h00);
        // R11 transfer done, then R2
        cur_req = "R11";
        ev(5, 0); chk("R11 xfer irq", irq, 1);
        rd(4, v); chk("R11 count cleared", v, 8'h00);
        rd(0, v); chk("R11 xfer stat", v, 8'h92);
        rd(1, v); chk("R11 xfer cause", v, 8'h10);
        cur_req = "R2";
        r0 = rises;
        ev(5, 0); ev(3, 1); chk("R2 still high", irq, 1);
        chk("R2 one rising edge", rises - r0, 1);
        rd(1, v); chk("R2 cause", v, 8'h18);
        // R6
        cur_req = "R6";
        tc_ld = 1; tc_val = 16'h0055; ff_ld = 1; ff_val = 8'h07; tick(); tc_ld = 0; ff_ld = 0;
        cmp(8'h08); chk("R6 irq", irq, 1);
        rd(2, v); chk("R6 seq", v, 8'h00);
        rd(3, v); chk("R6 flags", v, 8'h00);
        rd(4, v); chk("R6 count", v, 8'h00);
        rd(6, v); chk("R6 status byte", v, 8'h08);
        rd(0, v); chk("R6 stat", v, 8'h93);
        rd(1, v); chk("R6 cause", v, 8'h10);
        // R4 and R5
        cur_req = "R4";
        ev(3, 2);
        cmp(8'h01); cmp(8'h02);
        rd(0, v); chk("R4 stat unchanged", v, 8'h92);
        rd(6, v); chk("R4 status byte unchanged", v, 8'h08);
        cur_req = "R5";
        rd(1, v); chk("R5 acked cause", v, 8'h18);
        chk("R5 gap low", irq, 0);
        tick(); chk("R5 reposted", irq, 1);
        rd(6, v); chk("R5 newest status", v, 8'h02);
        rd(1, v); chk("R5 cause", v, 8'h10);
        // R7
        cur_req = "R7";
        ev(1, 0); chk("R7 loud irq", irq, 1);
        rd(1, v); chk("R7 cause", v, 8'h80);
        cfg_rst_quiet = 1;
        ev(1, 0); chk("R7 quiet irq", irq, 0);
        rd(1, v); chk("R7 quiet cause", v, 8'h80);
        cfg_rst_quiet = 0;
        // R8
        cur_req = "R8";
        ev(2, 0); chk("R8 irq", irq, 1);
        rd(0, v); chk("R8 stat", v, 8'h80);
        rd(2, v); chk("R8 seq", v, 8'h00);
        rd(1, v); chk("R8 cause", v, 8'h20);
        // R9
        cur_req = "R9";
        ff_ld = 1; ff_val = 8'h03; tick(); ff_ld = 0;
        ev(0, 0); chk("R9 no irq", irq, 0);
        rd(3, v); chk("R9 flags", v, 8'h00);
        rd(2, v); chk("R9 seq", v, 8'h00);
        rd(1, v); chk("R9 cause", v, 8'h08);
        // R11 message done and ignored kinds
        cur_req = "R11";
        ev(4, 0); chk("R11 msg irq", irq, 1);
        rd(2, v); chk("R11 msg seq", v, 8'h00);
        rd(1, v); chk("R11 msg cause", v, 8'h20);
        ev(7, 0); ev(6, 0); chk("R11 ignored irq", irq, 0);
        rd(2, v); chk("R11 ignored seq", v, 8'h04);
        // R12
        cur_req = "R12";
        ev(3, 3);
        rd_en = 1; rd_addr = 1; ev_valid = 1; ev_kind = 3; ev_phase = 1; tick();
        rd_en = 0; ev_valid = 0;
        chk("R12 old cause", rd_data, 8'h18); chk("R12 irq kept", irq, 1);
        rd(0, v); chk("R12 stat", v, 8'h91);
        rd_en = 1; rd_addr = 1; ev_valid = 1; ev_kind = 0; tick();
        rd_en = 0; ev_valid = 0;
        chk("R12 flush old cause", rd_data, 8'h18); chk("R12 flush irq", irq, 0);
        rd(1, v); chk("R12 flush cause", v, 8'h08);
        // R13
        cur_req = "R13";
        drq_raise = 1; tick(); drq_raise = 0; chk("R13 drq set", drq, 1);
        drq_raise = 1; drq_drop = 1; tick(); drq_raise = 0; drq_drop = 0;
        chk("R13 drop wins", drq, 0);
        drq_raise = 1; tick(); drq_raise = 0;
        ev(3, 2); cmp(8'h04);
        soft_rst = 1; tick(); soft_rst = 0;
        chk("R13 irq", irq, 0); chk("R13 drq", drq, 0);
        tick(); tick(); chk("R13 nothing reposted", irq, 0);
        rd(0, v); chk("R13 stat", v, 8'h00);
        rd(6, v); chk("R13 status byte", v, 8'h00);
        tick();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule